// File: doc/BRIEF.md
# Fast Overcurrent Trip Detector

This block takes the one-bit output of a sigma-delta modulator that measures one phase current. It runs the bitstream through a third-order sinc filter with a short decimation ratio, so that a fault shows up within a few microseconds rather than after a long filter has settled. The filter uses three running-sum stages, keeps one sample in every M, and then applies three first-difference stages. The result is re-centred so that a 50 % density reads zero, and it is emitted as a signed sample once per output period.

Each re-centred sample past the start-up window is reduced to its magnitude and compared against a programmable limit. An excursion sets a sticky overcurrent flag. A software enable decides whether that flag also drives the motor-disable output directly. The flag is released only by an explicit clear strobe, and only if the most recent compared sample is back inside the limit. A filter restart, normally issued by the PWM timer, zeroes the filter and reopens the start-up window. A restart does not release a trip that has already been latched.

Top module: `oc_trip_detect`

## Requirements
- R1: While rst_n is low at a clock edge, sample, sample_vld, oc_flag and drive_kill all read 0 after that edge.
- R2: sample_vld is high for exactly one clock in every 16 clocks when rate_sel is 0, and in every 8 clocks when rate_sel is 1.
- R3: Suppose the input is held constant long enough for the filter to settle (four or more outputs after a restart). All-ones input then reads +M³/2 (+2048 for M=16, +256 for M=8), and all-zeros input reads −M³/2.
- R4: An alternating 1,0 input settles to a sample of exactly 0 at both ratios.
- R5: A compared sample trips only when its magnitude is strictly greater than limit. A magnitude equal to limit does not trip.
- R6: The first three samples after reset or after a restart are never compared, whatever their value.
- R7: After oc_flag is set, it stays high when later samples fall back inside the limit.
- R8: trip_clr clears oc_flag only when the latest compared sample was within the limit. If that sample was over the limit, trip_clr has no effect.
- R9: drive_kill equals oc_flag when trip_en is 1 and is 0 when trip_en is 0.
- R10: restart zeroes the filter and the start-up window but leaves a latched oc_flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; bit_in is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Sigma-delta bitstream |
| restart | input | 1 | Synchronous filter restart from the PWM timer |
| rate_sel | input | 1 | 0 selects M=16, 1 selects M=8 |
| limit | input | 13 | Unsigned magnitude limit for the trip comparison |
| trip_en | input | 1 | Lets the latched trip drive drive_kill |
| trip_clr | input | 1 | One-clock strobe that requests release of the trip |
| sample | output | 13 | Signed re-centred filter output |
| sample_vld | output | 1 | One-clock pulse marking a new sample |
| oc_flag | output | 1 | Latched overcurrent indication |
| drive_kill | output | 1 | Direct motor-disable output |

## Verification
The embedded checks assume that rate_sel changes only in a clock where restart is also high. Without that, the decimation counter and the bias in use could disagree for one period, and the sample range check would no longer hold. The bench therefore changes rate_sel only inside its restart task, in the same clock as the restart pulse. It also holds every input pattern for at least six output periods before it reads a settled value. The bench issues clear strobes right after a sample pulse, so that no comparison lands in the same clock as the strobe.

// File: rtl/oc_pkg.sv
// Package: shared constants and helpers for the overcurrent trip path.
// Assumes decimation ratios are powers of two given by their log2.
package oc_pkg;
    // Number of samples hidden after a restart while the filter fills.
    localparam int SETTLE_OUTPUTS = 3;

    // Accumulator width needed by a third-order filter of ratio 2**log2m.
    function automatic int acc_width(input int log2m);
        return 1 + 3 * log2m;
    endfunction
endpackage

// File: rtl/oc_integrators.sv
// Module: three cascaded running-sum stages of the sinc3 filter.
// Assumes W is wide enough that modular wrap cancels in the difference stages.
module oc_integrators #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bit_in,
    output logic [W-1:0] acc_out
);
    logic [W-1:0] stage_q [3];

    for (genvar g = 0; g < 3; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage accumulates the raw bitstream.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) stage_q[0] <= '0;
                else               stage_q[0] <= stage_q[0] + W'(bit_in);
            end
        end else begin : g_next
            // Later stages accumulate the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) stage_q[g] <= '0;
                else               stage_q[g] <= stage_q[g] + stage_q[g-1];
            end
        end
    end

    assign acc_out = stage_q[2];
endmodule

// File: rtl/oc_decim_comb.sv
// Module: keeps one accumulator value in every M, applies three difference
// stages, removes the mid-scale bias and registers a signed sample.
// Assumes fast only changes together with clr.
module oc_decim_comb #(
    parameter int SLOW_LOG2 = 4,
    parameter int FAST_LOG2 = 3,
    parameter int W         = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                fast,
    input  logic [W-1:0]        acc_in,
    output logic signed [W-1:0] sample,
    output logic                vld
);
    localparam int CW = SLOW_LOG2;
    localparam logic [CW-1:0] LAST_SLOW = CW'((1 << SLOW_LOG2) - 1);
    localparam logic [CW-1:0] LAST_FAST = CW'((1 << FAST_LOG2) - 1);
    localparam logic signed [W:0] BIAS_SLOW = (W+1)'(1 << (3 * SLOW_LOG2 - 1));
    localparam logic signed [W:0] BIAS_FAST = (W+1)'(1 << (3 * FAST_LOG2 - 1));

    logic [CW-1:0]      phase_q;
    logic               strobe;
    logic [W-1:0]       diff [4];
    logic [W-1:0]       dly_q [3];
    logic signed [W:0]  centred;

    assign strobe = (phase_q == (fast ? LAST_FAST : LAST_SLOW));

    // Decimation phase counter, wraps at M-1.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) phase_q <= '0;
        else if (strobe)   phase_q <= '0;
        else               phase_q <= phase_q + 1'b1;
    end

    assign diff[0] = acc_in;

    for (genvar k = 0; k < 3; k++) begin : g_diff
        assign diff[k+1] = diff[k] - dly_q[k];
        // Each difference stage remembers its input from the previous kept sample.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) dly_q[k] <= '0;
            else if (strobe)   dly_q[k] <= diff[k];
        end
    end

    assign centred = $signed({1'b0, diff[3]}) - (fast ? BIAS_FAST : BIAS_SLOW);

    // Output register: signed sample and its one-clock valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
            vld    <= 1'b0;
        end else if (clr) begin
            sample <= '0;
            vld    <= 1'b0;
        end else begin
            vld <= strobe;
            if (strobe) sample <= centred[W-1:0];
        end
    end

    // R2
    vld_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);
endmodule

// File: rtl/oc_trip_latch.sv
// Module: hides the first samples after a restart, compares the magnitude of
// later samples with the limit, and holds a sticky trip released by a strobe.
// Assumes vld is a one-clock pulse and sample is valid while vld is high.
module oc_trip_latch #(
    parameter int W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                vld,
    input  logic signed [W-1:0] sample,
    input  logic [W-1:0]        limit,
    input  logic                trip_clr,
    output logic                flag
);
    import oc_pkg::*;

    logic [1:0]  seen_q;
    logic        armed;
    logic        hot_q;
    logic [W:0]  ext;
    logic [W:0]  mag;
    logic        exceed;

    assign armed  = (seen_q == 2'(SETTLE_OUTPUTS));
    assign ext    = {sample[W-1], sample};
    assign mag    = ext[W] ? (~ext + 1'b1) : ext;
    assign exceed = (mag > {1'b0, limit});

    // Start-up window counter and last-comparison memory.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen_q <= '0;
            hot_q  <= 1'b0;
        end else if (vld) begin
            if (!armed) seen_q <= seen_q + 1'b1;
            else        hot_q  <= exceed;
        end
    end

    // Sticky trip: set by an armed excursion, released by a strobe when calm.
    always_ff @(posedge clk) begin
        if (!rst_n)                               flag <= 1'b0;
        else if (vld && armed && exceed && !clr)  flag <= 1'b1;
        else if (trip_clr && !hot_q)              flag <= 1'b0;
    end

    // R6
    trip_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(vld));
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(trip_clr));
    // R8
    clr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_clr && hot_q && flag) |=> flag);
endmodule

// File: rtl/oc_trip_detect.sv
// Module: top of the fast overcurrent path: sinc3 filter at ratio 16 or 8,
// re-centred sample, sticky trip and gated motor-disable output.
// Assumes rate_sel changes only in a clock where restart is high.
module oc_trip_detect #(
    parameter int  SLOW_LOG2 = 4,
    parameter int  FAST_LOG2 = 3,
    localparam int W         = oc_pkg::acc_width(SLOW_LOG2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_in,
    input  logic                restart,
    input  logic                rate_sel,
    input  logic [W-1:0]        limit,
    input  logic                trip_en,
    input  logic                trip_clr,
    output logic signed [W-1:0] sample,
    output logic                sample_vld,
    output logic                oc_flag,
    output logic                drive_kill
);
    localparam logic signed [W:0] SPAN_SLOW = (W+1)'(1 << (3 * SLOW_LOG2 - 1));
    localparam logic signed [W:0] SPAN_FAST = (W+1)'(1 << (3 * FAST_LOG2 - 1));

    logic [W-1:0]      acc3;
    logic signed [W:0] span;

    oc_integrators #(.W(W)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .bit_in  (bit_in),
        .acc_out (acc3)
    );

    oc_decim_comb #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2), .W(W)) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart),
        .fast   (rate_sel),
        .acc_in (acc3),
        .sample (sample),
        .vld    (sample_vld)
    );

    oc_trip_latch #(.W(W)) u_trip (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (restart),
        .vld      (sample_vld),
        .sample   (sample),
        .limit    (limit),
        .trip_clr (trip_clr),
        .flag     (oc_flag)
    );

    // Motor-disable output follows the trip only when software allows it.
    assign drive_kill = oc_flag & trip_en;

    assign span = rate_sel ? SPAN_FAST : SPAN_SLOW;

    // R3
    sample_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> ($signed({sample[W-1], sample}) <= span &&
                        $signed({sample[W-1], sample}) >= -span));
    // R2 (input assumption: ratio changes only with a restart)
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_sel) |-> restart);
endmodule

// File: tb/oc_trip_detect_test.sv
// Bench: directed scenarios, one task each, for the fast overcurrent detector.
module oc_trip_detect_test;
    localparam int W = 13;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bit_in = 1'b0;
    logic                restart = 1'b0;
    logic                rate_sel = 1'b0;
    logic [W-1:0]        limit = '1;
    logic                trip_en = 1'b0;
    logic                trip_clr = 1'b0;
    logic signed [W-1:0] sample;
    logic                sample_vld;
    logic                oc_flag;
    logic                drive_kill;

    int checks = 0;
    int failures = 0;
    int pat = 0;          // 0 zeros, 1 ones, 2 alternating
    logic toggle = 1'b0;

    oc_trip_detect uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .restart(restart),
        .rate_sel(rate_sel), .limit(limit), .trip_en(trip_en),
        .trip_clr(trip_clr), .sample(sample), .sample_vld(sample_vld),
        .oc_flag(oc_flag), .drive_kill(drive_kill)
    );

    always #10 clk = ~clk;

    // Bitstream generator, updated away from the sampling edge.
    always @(negedge clk) begin
        toggle <= ~toggle;
        case (pat)
            0:       bit_in <= 1'b0;
            1:       bit_in <= 1'b1;
            default: bit_in <= toggle;
        endcase
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_vld();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!sample_vld && guard < 100);
    endtask

    task automatic wait_outputs(input int n);
        for (int i = 0; i < n; i++) wait_vld();
    endtask

    task automatic do_restart(input logic sel);
        @(negedge clk);
        restart = 1'b1;
        rate_sel = sel;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic pulse_clr();
        wait_vld();
        trip_clr = 1'b1;
        @(negedge clk);
        trip_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        // R1
        check(sample == 0 && !sample_vld, "R1 sample/vld", int'(sample), 0);
        check(!oc_flag && !drive_kill, "R1 flag/kill", int'(oc_flag) + int'(drive_kill), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_rate();
        int gap;
        pat = 2;
        do_restart(1'b0);
        wait_vld();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!sample_vld && gap < 100);
        check(gap == 16, "R2 period M=16", gap, 16);
        do_restart(1'b1);
        wait_vld();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!sample_vld && gap < 100);
        check(gap == 8, "R2 period M=8", gap, 8);
    endtask

    task automatic t_levels();
        limit = '1;
        pat = 1;
        do_restart(1'b0);
        wait_outputs(6);
        check(sample == 2048, "R3 ones M=16", int'(sample), 2048);
        pat = 0;
        wait_outputs(6);
        check(sample == -2048, "R3 zeros M=16", int'(sample), -2048);
        pat = 2;
        wait_outputs(6);
        check(sample == 0, "R4 alternating M=16", int'(sample), 0);
        pat = 1;
        do_restart(1'b1);
        wait_outputs(6);
        check(sample == 256, "R3 ones M=8", int'(sample), 256);
        pat = 2;
        wait_outputs(6);
        check(sample == 0, "R4 alternating M=8", int'(sample), 0);
    endtask

    task automatic t_threshold();
        pat = 1;
        limit = 13'd2048;
        do_restart(1'b0);
        wait_outputs(8);
        check(!oc_flag, "R5 equal no trip", int'(oc_flag), 0);
        limit = 13'd2047;
        wait_outputs(2);
        check(oc_flag, "R5 above trips", int'(oc_flag), 1);
        trip_en = 1'b1;
        @(negedge clk);
        check(drive_kill, "R9 kill enabled", int'(drive_kill), 1);
        trip_en = 1'b0;
        @(negedge clk);
        check(!drive_kill, "R9 kill gated", int'(drive_kill), 0);
        pat = 2;
        wait_outputs(6);
        check(oc_flag, "R7 flag held", int'(oc_flag), 1);
    endtask

    task automatic t_clear();
        pat = 1;
        limit = 13'd100;
        wait_outputs(6);
        pulse_clr();
        check(oc_flag, "R8 clear ignored while over", int'(oc_flag), 1);
        pat = 2;
        wait_outputs(6);
        pulse_clr();
        check(!oc_flag, "R8 clear when calm", int'(oc_flag), 0);
    endtask

    task automatic t_restart_keep();
        pat = 1;
        limit = 13'd100;
        wait_outputs(4);
        check(oc_flag, "R10 setup trip", int'(oc_flag), 1);
        pat = 2;
        do_restart(1'b0);
        wait_outputs(1);
        check(oc_flag, "R10 flag survives restart", int'(oc_flag), 1);
        wait_outputs(6);
        check(sample == 0, "R10 filter refills", int'(sample), 0);
        pulse_clr();
        check(!oc_flag, "R10 released after restart", int'(oc_flag), 0);
    endtask

    task automatic t_settle();
        limit = 13'd1000;
        pat = 2;
        do_restart(1'b0);
        wait_vld();
        check(sample < -1000 || sample > 1000, "R6 first sample is large",
              int'(sample), -1001);
        wait_outputs(10);
        check(!oc_flag, "R6 start-up samples ignored", int'(oc_flag), 0);
    endtask

    task automatic t_fast_threshold();
        pat = 1;
        limit = 13'd256;
        do_restart(1'b1);
        wait_outputs(8);
        check(!oc_flag, "R5 equal no trip M=8", int'(oc_flag), 0);
        limit = 13'd255;
        wait_outputs(2);
        check(oc_flag, "R5 above trips M=8", int'(oc_flag), 1);
    endtask

    initial begin
        t_reset();
        t_rate();
        t_levels();
        t_threshold();
        t_clear();
        t_restart_keep();
        t_settle();
        t_fast_threshold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure.
    initial begin
        #3000000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule